// File: doc/BRIEF.md
# PHY Management Register Bridge

This block lets a host reach the management registers of an Ethernet PHY through a single 32-bit access register. The host writes one command word that holds a direction flag, a register number and, for writes, the data. The bridge then runs a complete serial management frame on the MDC/MDIO pins. When the frame ends, the bridge flips the flag bit in the same register to show that the transaction is done.

The flag has opposite meanings for the two directions. A write is issued with the flag set, and the bridge clears the flag when the frame has gone out. A read is issued with the flag clear. The bridge sets the flag once the returned data sits in the low half of the register. The host polls the register until the flag reaches the value it expects. While a frame is running the flag holds its command value, so the host can see that the bridge is busy.

The management clock comes from the system clock through a parameterised divider. The bridge changes MDIO on the falling edge of MDC and samples it on the rising edge. The PHY address is a build-time parameter.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: During and after reset, the access register reads zero, MDC is low and the MDIO output enable is low.
- R2: A command with bit 31 = 1 sends a 64-bit write frame, all of it driven, MSB first. The frame is 32 ones, start `01`, opcode `01`, the 5-bit PHY address, register bits 20:16 of the command, turnaround `10`, then data bits 15:0.
- R3: When a write frame ends, bit 31 of the register reads 0. Bits 23:0 keep the values written.
- R4: A command with bit 31 = 0 sends a read frame. It has start `01`, opcode `10`, the PHY address and the register number. The output enable is low for the last 18 bit periods (turnaround and data), and the first 46 bit periods are driven.
- R5: When a read frame ends, bits 15:0 hold the 16 bits sampled from MDIO on the last 16 rising MDC edges, MSB first, and bit 31 reads 1. Bits 23:16 keep the register number.
- R6: MDC has a period of 2*DIV_HALF system clocks while a frame runs and is low when the bridge is idle. MDIO output and enable change only where MDC falls.
- R7: A command written while a frame is running is ignored. The register, the frame on the wire and the final result are those of the first command.
- R8: A transaction completes within 64*2*DIV_HALF + 2 system clocks of the command write. With the default divider this is well under 2000 host polls.
- R9: Bits 30:24 of the register always read 0. All 8 bits of the register-number field read back as written, and only its low 5 bits go on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host writes the access register this cycle |
| host_wr_data | input | 32 | Command word from the host |
| host_rd_data | output | 32 | Current access register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The assertions check several properties on every cycle. MDC stays low while the bridge is idle. The pin changes only on a falling MDC edge. The enable is held for the whole of a write frame and released for the read turnaround and data. The register does not move while a frame runs, and the flag lands on the correct polarity at completion. A counter bounds how long any frame can run. Only the bench scenarios can show the frame contents bit by bit, the data returned by a PHY model, the MDC period and the rejection of a second command against the final register value.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int FRAME_BITS   = 64;
  localparam int DRIVEN_RD    = 46;   // bits driven before read turnaround
  localparam int RD_DATA_FROM = 48;   // first read data bit index

  // Serial management frame, MSB is sent first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic rd, input logic [4:0] phy, input logic [4:0] ra,
      input logic [15:0] wd);
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b00 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, phy, ra, ta, (rd ? 16'h0000 : wd)};
  endfunction

  // Whether the bridge drives the pin for bit position idx.
  function automatic logic drives_bit(input logic rd, input int idx);
    return !rd || (idx < DRIVEN_RD);
  endfunction
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick    = run && (cnt == LAST);
  assign rise_ev = tick && !mdc;
  assign fall_ev = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import phy_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cmd,
  input  logic        rise_ev,
  input  logic        fall_ev,
  input  logic        mdio_i,
  output logic        busy,
  output logic        is_read,
  output logic        done_ev,
  output logic [5:0]  bit_idx,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [FRAME_BITS-1:0] sr;
  logic                  last_bit;

  assign last_bit = (bit_idx == 6'(FRAME_BITS - 1));
  assign done_ev  = busy && fall_ev && last_bit;
  assign mdio_o   = sr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '0;
      busy    <= 1'b0;
      is_read <= 1'b0;
      bit_idx <= '0;
      rd_data <= '0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      sr      <= build_frame(!cmd[31], PHY_ADDR, cmd[20:16], cmd[15:0]);
      busy    <= 1'b1;
      is_read <= !cmd[31];
      bit_idx <= '0;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_ev && is_read && (int'(bit_idx) >= RD_DATA_FROM))
        rd_data <= {rd_data[14:0], mdio_i};
      if (fall_ev) begin
        if (last_bit) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sr      <= {sr[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= drives_bit(is_read, int'(bit_idx) + 1);
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_cmd_reg.sv
module mgmt_cmd_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] wr_data,
  input  logic        done_ev,
  input  logic        is_read,
  input  logic [15:0] rd_data,
  output logic [31:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (start) begin
      acc <= {wr_data[31], 7'b0, wr_data[23:0]};
    end else if (done_ev) begin
      if (is_read) begin
        acc[31]   <= 1'b1;
        acc[15:0] <= rd_data;
      end else begin
        acc[31] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge #(
  parameter int         DIV_HALF = 4,
  parameter logic [4:0] PHY_ADDR = 5'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic [31:0] host_wr_data,
  output logic [31:0] host_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        busy, is_read, done_ev, start, rise_ev, fall_ev;
  logic [5:0]  bit_idx;
  logic [15:0] rd_data;

  assign start = host_wr_en && !busy;

  mgmt_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev));

  mgmt_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(host_wr_data),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
    .busy(busy), .is_read(is_read), .done_ev(done_ev), .bit_idx(bit_idx),
    .rd_data(rd_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  mgmt_cmd_reg u_reg (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_data(host_wr_data),
    .done_ev(done_ev), .is_read(is_read), .rd_data(rd_data),
    .acc(host_rd_data));
endmodule

// File: rtl/phy_mgmt_bridge_chk.sv
module phy_mgmt_bridge_chk #(
  parameter int DIV_HALF = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        is_read,
  input logic        done_ev,
  input logic [5:0]  bit_idx,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] acc
);
  localparam int LIMIT = 64 * 2 * DIV_HALF + 2;
  int busy_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cycles <= 0;
    else                 busy_cycles <= busy_cycles + 1;
  end

  a_r6_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o) || mdio_oe != $past(mdio_oe)))
      |-> $fell(mdc));

  a_r2_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_read) |-> mdio_oe);

  a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_read && bit_idx >= 6'd46) |-> !mdio_oe);

  a_r7_reg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_ev) |=> $stable(acc));

  a_r3_write_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && !is_read) |=> !acc[31]);

  a_r5_read_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && is_read) |=> acc[31]);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc[30:24] == 7'd0);

  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cycles < LIMIT);
endmodule

bind phy_mgmt_bridge phy_mgmt_bridge_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .is_read(is_read),
  .done_ev(done_ev), .bit_idx(bit_idx), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .acc(host_rd_data));

// File: tb/phy_mgmt_bridge_test.sv
module phy_mgmt_bridge_test;
  localparam int         CLK_PERIOD = 10;
  localparam int         DIVH       = 4;
  localparam logic [4:0] PHYA       = 5'h01;
  localparam int         NVEC       = 4;

  // command words and PHY responses
  localparam logic [31:0] VCMD  [NVEC] = '{32'h8004_01E1, 32'h0001_0000,
                                           32'hFFE9_0200, 32'h001F_0000};
  localparam logic [15:0] VRESP [NVEC] = '{16'h0000, 16'h796D,
                                           16'h0000, 16'h8001};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd;
  logic mdc, mdio_o, mdio_oe;

  int checks = 0, fails = 0, cyc = 0;
  int rcount = 0, last_rise = 0, period = 0;
  logic [63:0] cap_bit, cap_oe;
  logic [15:0] resp = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_mgmt_bridge #(.DIV_HALF(DIVH), .PHY_ADDR(PHYA)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en), .host_wr_data(wr_data),
    .host_rd_data(rd), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  // PHY model: record the wire on rising MDC, answer on falling MDC
  always @(posedge mdc) begin
    if (rcount < 64) begin
      cap_bit[63 - rcount] = mdio_o;
      cap_oe[63 - rcount]  = mdio_oe;
    end
    period    = cyc - last_rise;
    last_rise = cyc;
    rcount    = rcount + 1;
  end
  always @(negedge mdc) begin
    if (rcount >= 48 && rcount < 64) mdio_i = resp[63 - rcount];
    else                              mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected wire value for bit i, written per field
  function automatic logic exp_bit(input logic rd_op, input int i,
                                   input logic [4:0] ra, input logic [15:0] d);
    if (i < 32) return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return rd_op;
    if (i == 35) return !rd_op;
    if (i < 41) return PHYA[40 - i];
    if (i < 46) return ra[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return d[63 - i];
  endfunction

  task automatic issue(input logic [31:0] c);
    @(negedge clk); wr_en = 1'b1; wr_data = c;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_cmd(input logic [31:0] c, input logic [15:0] r,
                         input int inject_at, input logic [31:0] inject_cmd,
                         output int lat);
    logic want;
    want = !c[31];
    resp = r; rcount = 0; cap_bit = '0; cap_oe = '0;
    issue(c);
    lat = 1;
    while (rd[31] != want && lat < 2000) begin
      if (lat == inject_at) begin
        wr_en = 1'b1; wr_data = inject_cmd;
        @(negedge clk); wr_en = 1'b0; lat++;
      end else begin
        @(negedge clk); lat++;
      end
    end
  endtask

  task automatic check_frame(input logic [31:0] c, input logic [15:0] r,
                             input string tag);
    logic rdop;
    int bad, drv;
    rdop = !c[31];
    bad = 0; drv = 0;
    for (int i = 0; i < 64; i++) begin
      if (cap_oe[63 - i]) drv++;
      if (cap_oe[63 - i] && cap_bit[63 - i] != exp_bit(rdop, i, c[20:16], c[15:0]))
        bad++;
    end
    check(bad == 0, {tag, " frame bits"}, 64'(bad), 64'd0);
    check(drv == (rdop ? 46 : 64), {tag, " driven bit count"},
          64'(drv), rdop ? 64'd46 : 64'd64);
    check(rcount == 64, {tag, " MDC rising edges"}, 64'(rcount), 64'd64);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    logic [31:0] exp;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(rd == 32'h0, "R1 reg in reset", 64'(rd), 64'h0);
    check(!mdc && !mdio_oe, "R1 pins in reset", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rd == 32'h0 && !mdc, "R1 after reset", 64'(rd), 64'h0);

    // table walk: R2 R3 write, R4 R5 read, R9 reserved field
    for (int v = 0; v < NVEC; v++) begin
      run_cmd(VCMD[v], VRESP[v], 0, 32'h0, lat);
      if (VCMD[v][31]) begin
        exp = {8'h00, VCMD[v][23:0]};
        check_frame(VCMD[v], VRESP[v], "R2 write");
        check(rd == exp, "R3 R9 write completion reg", 64'(rd), 64'(exp));
      end else begin
        exp = {1'b1, 7'd0, VCMD[v][23:16], VRESP[v]};
        check_frame(VCMD[v], VRESP[v], "R4 read");
        check(rd == exp, "R5 R9 read completion reg", 64'(rd), 64'(exp));
      end
      check(lat <= 64 * 2 * DIVH + 2, "R8 completion latency",
            64'(lat), 64'(64 * 2 * DIVH + 2));
      repeat (5) @(negedge clk);
    end

    // R6: MDC period and idle level
    check(period == 2 * DIVH, "R6 MDC period", 64'(period), 64'(2 * DIVH));
    check(!mdc && !mdio_oe, "R6 idle MDC low", {62'd0, mdc, mdio_oe}, 64'd0);

    // R7: second command during a frame is ignored
    run_cmd(32'h8010_AAAA, 16'h0, 40, 32'h0002_0000, lat);
    check(rd == 32'h0010_AAAA, "R7 reg after ignored cmd", 64'(rd), 64'h0010_AAAA);
    check_frame(32'h8010_AAAA, 16'h0, "R7 frame of first cmd");
    rcount = 0;
    repeat (40) @(negedge clk);
    check(rcount == 0 && rd == 32'h0010_AAAA, "R7 no second frame",
          64'(rcount), 64'd0);

    finish_run();
  end
endmodule